// File: doc/BRIEF.md
# Character display command engine

This block sits between a microprocessor bus and the memories of a character display controller. It decodes the command bytes the host writes and keeps the controller's state: the address counter, the select bit that aims the counter at display memory or pattern memory, the busy flag, the entry, display and interface modes, and the display shift offset. Data accesses go to an external RAM port, and each one moves the counter automatically in the chosen direction.

Every command and data access keeps the busy flag set for a number of clock ticks set by parameter, one tick per clock. Clear and home take a long hold and all the others a short one. The clear command uses its busy window to fill the display memory with the blank code, one location per clock. While the flag is set, only status reads are honoured. The bus can run eight bits at a time, or as two four-bit halves on the upper data lines with the high half first.

Top module: `lcd_cmd_engine`

## Requirements
- R1: A strobe with select low and read high returns the busy flag in bit 7 and the address counter in bits 6..0. It is honoured even while busy and does not set the busy flag.
- R2: A command byte is decoded by its highest set bit: 1xxxxxxx sets a display address (bits 6..0), 01xxxxxx sets a pattern address (bits 5..0), 001 L N F xx is function set, 0001 S R xx is shift, 00001 D C B is display control, 000001 I S is entry mode, 0000001x is home, 00000001 is clear, and 00000000 does nothing and leaves the busy flag clear.
- R3: The busy flag rises on the clock that accepts the access and stays high for LONG_TICKS clocks after clear or home, and for SHORT_TICKS clocks after any other command or any data read or write.
- R4: Clear writes the blank code 20h into all DD_BYTES display locations, sets the shift offset to 0 and loads display address 0. It writes RAM only while busy.
- R5: Home sets the shift offset to 0 and loads display address 0, and leaves display memory unchanged.
- R6: After each data read or write the counter steps by +1 when I=1 and by -1 when I=0. When S=1, each data write (not a read) also moves the shift offset by +1 for I=1 or by -1 for I=0.
- R7: In two-line mode the display addresses 27h and 40h are adjacent, and 67h wraps to 00h (and back when decrementing). In one-line mode 4Fh and 00h are adjacent. Pattern addresses wrap modulo 64.
- R8: A shift command with S=0 moves the counter (R=1 up, R=0 down). With S=1 it moves the shift offset (R=0 +1, R=1 -1), modulo 40 in two-line mode and modulo 80 in one-line mode.
- R9: Display control sets disp_on, cursor_on and blink_on from D, C and B. Function set sets bus_8bit, two_line and tall_font from L, N and F.
- R10: With bus_8bit low, each byte takes two strobes on bus_din[7:4], high half first, and reads return each half on bus_dout[7:4]. A function set returns the half sequence to its first half.
- R11: While busy, any strobe other than a status read has no effect.
- R12: After a pattern address set, data accesses go to pattern memory (ram_sel=1). In two-line mode, display address 40h+k maps to RAM location 40+k.
- R13: After reset the busy flag is low, the counter is display address 0, I=1, the interface is 8-bit, all other modes are 0, the shift offset is 0 and bus_dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one busy tick per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_rs | input | 1 | 0: command/status, 1: data |
| bus_rw | input | 1 | 1: read, 0: write |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host, registered |
| busy | output | 1 | Busy flag |
| ram_sel | output | 1 | 1: pattern memory, 0: display memory |
| ram_addr | output | 7 | RAM location |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, combinational |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Blink at cursor |
| bus_8bit | output | 1 | 1: byte transfers, 0: half-byte transfers |
| two_line | output | 1 | Two-line addressing |
| tall_font | output | 1 | Tall font selected |
| shift_pos | output | 7 | Display shift offset |

## Verification
A wrong address counter shows on the next status read, and on the RAM address of the next data access in the same clock. A wrong step or wrap therefore shows up one access later as data read back from the wrong location. A busy counter that is off by one shows at the busy port on the first clock of the error, and it also makes a following access get dropped or accepted wrongly. A mode register or half-byte phase that goes wrong shows at the mode ports one clock after the accepting edge, or as swapped halves on the next four-bit transfer.

// File: rtl/lcd_cmd_engine.sv
module lcd_cmd_engine #(
  parameter int DD_BYTES    = 80,
  parameter int LINE_LEN    = 40,
  parameter int LINE2_BASE  = 64,
  parameter int LONG_TICKS  = 410,
  parameter int SHORT_TICKS = 10,
  parameter logic [7:0] BLANK = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_stb,
  input  logic       bus_rs,
  input  logic       bus_rw,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic       busy,
  output logic       ram_sel,
  output logic [6:0] ram_addr,
  output logic [7:0] ram_wdata,
  output logic       ram_we,
  input  logic [7:0] ram_rdata,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       bus_8bit,
  output logic       two_line,
  output logic       tall_font,
  output logic [6:0] shift_pos
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam logic [6:0] L1_END = 7'(LINE_LEN - 1);
  localparam logic [6:0] L2_BEG = 7'(LINE2_BASE);
  localparam logic [6:0] L2_END = 7'(LINE2_BASE + LINE_LEN - 1);
  localparam logic [6:0] DD_END = 7'(DD_BYTES - 1);
  localparam logic [6:0] L2_OFS = 7'(LINE2_BASE - LINE_LEN);

  logic [CW-1:0] busy_cnt;
  logic [6:0] ac, clr_idx;
  logic cg_sel, inc, ent_shift, clearing, nib_phase;
  logic [3:0] hi_nib;
  logic [7:0] rd_hold, dout_r;

  function automatic logic [6:0] ac_step(input logic [6:0] a, input logic up,
                                         input logic cg, input logic tl);
    if (cg) return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    if (tl) begin
      if (up) return (a == L1_END) ? L2_BEG : (a == L2_END) ? 7'd0 : a + 7'd1;
      return (a == 7'd0) ? L2_END : (a == L2_BEG) ? L1_END : a - 7'd1;
    end
    if (up) return (a == DD_END) ? 7'd0 : a + 7'd1;
    return (a == 7'd0) ? DD_END : a - 7'd1;
  endfunction

  function automatic logic [6:0] sh_step(input logic [6:0] s, input logic left,
                                         input logic tl);
    logic [6:0] lim;
    lim = tl ? L1_END : DD_END;
    if (left) return (s >= lim) ? 7'd0 : s + 7'd1;
    return (s == 7'd0 || s > lim) ? lim : s - 7'd1;
  endfunction

  wire stat_rd = bus_stb & ~bus_rs & bus_rw;
  wire accept  = bus_stb & (stat_rd | ~busy);
  wire second  = bus_8bit | nib_phase;
  wire exec    = accept & second;
  wire [7:0] byte_in = bus_8bit ? bus_din : {hi_nib, bus_din[7:4]};
  wire cmd = exec & ~bus_rs & ~bus_rw;
  wire dwr = exec & bus_rs & ~bus_rw;
  wire drd = exec & bus_rs & bus_rw;
  wire [7:0] rd_src = bus_rs ? ram_rdata : {busy, ac};
  wire [6:0] dd_phys = (two_line & ac[6]) ? ac - L2_OFS : ac;

  assign busy      = busy_cnt != '0;
  assign bus_dout  = dout_r;
  assign ram_sel   = ~clearing & cg_sel;
  assign ram_addr  = clearing ? clr_idx : (cg_sel ? {1'b0, ac[5:0]} : dd_phys);
  assign ram_we    = clearing | dwr;
  assign ram_wdata = clearing ? BLANK : byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0; ac <= '0; clr_idx <= '0; cg_sel <= 1'b0;
      inc <= 1'b1; ent_shift <= 1'b0; clearing <= 1'b0; nib_phase <= 1'b0;
      hi_nib <= '0; rd_hold <= '0; dout_r <= '0;
      disp_on <= 1'b0; cursor_on <= 1'b0; blink_on <= 1'b0;
      bus_8bit <= 1'b1; two_line <= 1'b0; tall_font <= 1'b0; shift_pos <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (clearing) begin
        clr_idx <= clr_idx + 7'd1;
        if (clr_idx == DD_END) clearing <= 1'b0;
      end
      if (accept & ~bus_8bit) begin
        nib_phase <= ~nib_phase;
        if (!nib_phase) hi_nib <= bus_din[7:4];
      end
      if (accept & bus_rw) begin
        if (second) dout_r <= bus_8bit ? rd_src : {rd_hold[3:0], 4'h0};
        else begin
          rd_hold <= rd_src;
          dout_r  <= {rd_src[7:4], 4'h0};
        end
      end
      if (drd | dwr) begin
        ac <= ac_step(ac, inc, cg_sel, two_line);
        busy_cnt <= CW'(SHORT_TICKS);
      end
      if (dwr & ent_shift) shift_pos <= sh_step(shift_pos, inc, two_line);
      if (cmd) begin
        casez (byte_in)
          8'b1???????: begin
            ac <= byte_in[6:0]; cg_sel <= 1'b0; busy_cnt <= CW'(SHORT_TICKS);
          end
          8'b01??????: begin
            ac <= {1'b0, byte_in[5:0]}; cg_sel <= 1'b1; busy_cnt <= CW'(SHORT_TICKS);
          end
          8'b001?????: begin
            bus_8bit <= byte_in[4]; two_line <= byte_in[3]; tall_font <= byte_in[2];
            nib_phase <= 1'b0; busy_cnt <= CW'(SHORT_TICKS);
          end
          8'b0001????: begin
            if (byte_in[3]) shift_pos <= sh_step(shift_pos, ~byte_in[2], two_line);
            else ac <= ac_step(ac, byte_in[2], cg_sel, two_line);
            busy_cnt <= CW'(SHORT_TICKS);
          end
          8'b00001???: begin
            disp_on <= byte_in[2]; cursor_on <= byte_in[1]; blink_on <= byte_in[0];
            busy_cnt <= CW'(SHORT_TICKS);
          end
          8'b000001??: begin
            inc <= byte_in[1]; ent_shift <= byte_in[0]; busy_cnt <= CW'(SHORT_TICKS);
          end
          8'b0000001?: begin
            ac <= '0; cg_sel <= 1'b0; shift_pos <= '0; busy_cnt <= CW'(LONG_TICKS);
          end
          8'b00000001: begin
            ac <= '0; cg_sel <= 1'b0; shift_pos <= '0; busy_cnt <= CW'(LONG_TICKS);
            clearing <= 1'b1; clr_idx <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_cmd_engine_chk.sv
module lcd_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_stb,
  input logic       bus_rs,
  input logic       bus_rw,
  input logic [7:0] bus_din,
  input logic [7:0] bus_dout,
  input logic       busy,
  input logic       bus_8bit,
  input logic       ram_we,
  input logic       ram_sel,
  input logic [7:0] ram_wdata,
  input logic       disp_on,
  input logic [6:0] shift_pos
);
  // R1
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb & ~bus_rs & bus_rw & bus_8bit |=> bus_dout[7] == $past(busy));
  // R1
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb & ~bus_rs & bus_rw & ~busy |=> ~busy);
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb & bus_8bit & ~busy & ~(~bus_rs & bus_rw) & (bus_rs | (bus_din != 8'h00)) |=> busy);
  // R4
  fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we & ~(bus_stb & bus_rs & ~bus_rw) |-> busy & ~ram_sel & (ram_wdata == 8'h20));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy & bus_stb & ~(~bus_rs & bus_rw) |=> $stable(disp_on) && $stable(shift_pos) && $stable(bus_8bit));
endmodule

bind lcd_cmd_engine lcd_cmd_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_rs(bus_rs), .bus_rw(bus_rw),
  .bus_din(bus_din), .bus_dout(bus_dout), .busy(busy), .bus_8bit(bus_8bit),
  .ram_we(ram_we), .ram_sel(ram_sel), .ram_wdata(ram_wdata),
  .disp_on(disp_on), .shift_pos(shift_pos)
);

// File: tb/test_lcd_cmd_engine.sv
`timescale 1ns/1ps
module test_lcd_cmd_engine;
  localparam int LONG  = 410;
  localparam int SHORT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_stb = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout, ram_wdata, ram_rdata;
  logic busy, ram_sel, ram_we, disp_on, cursor_on, blink_on, bus_8bit, two_line, tall_font;
  logic [6:0] ram_addr, shift_pos;

  always #2 clk = ~clk;

  lcd_cmd_engine i_lcd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_din(bus_din), .bus_dout(bus_dout), .busy(busy), .ram_sel(ram_sel),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .bus_8bit(bus_8bit),
    .two_line(two_line), .tall_font(tall_font), .shift_pos(shift_pos));

  logic [7:0] ddm [128];
  logic [7:0] cgm [64];
  initial begin
    for (int i = 0; i < 128; i++) ddm[i] = 8'h00;
    for (int i = 0; i < 64; i++) cgm[i] = 8'h00;
  end
  assign ram_rdata = ram_sel ? cgm[ram_addr[5:0]] : ddm[ram_addr];
  always @(posedge clk) if (ram_we) begin
    if (ram_sel) cgm[ram_addr[5:0]] <= ram_wdata;
    else ddm[ram_addr] <= ram_wdata;
  end

  int checks = 0, fails = 0, proto = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_ac, m_shift;
  bit m_cg, m_id, m_s, m_d, m_c, m_b, m_dl, m_n, m_f, m_nib;
  logic [3:0] m_hi;
  logic [7:0] m_hold, m_dout;
  logic [7:0] mdd [128];
  logic [7:0] mcg [64];
  bit m_live = 0;

  function automatic int stepf(int a, bit up, bit cg, bit tl);
    if (cg) return up ? (a + 1) % 64 : (a + 63) % 64;
    if (tl) begin
      if (up) return a == 39 ? 64 : a == 103 ? 0 : (a + 1) % 128;
      return a == 0 ? 103 : a == 64 ? 39 : a - 1;
    end
    if (up) return a == 79 ? 0 : (a + 1) % 128;
    return a == 0 ? 79 : a - 1;
  endfunction

  function automatic int shf(int s, bit left, bit tl);
    int lim = tl ? 39 : 79;
    if (left) return s >= lim ? 0 : s + 1;
    return (s == 0 || s > lim) ? lim : s - 1;
  endfunction

  function automatic logic [7:0] mread(int ac);
    if (m_cg) return mcg[ac % 64];
    return mdd[(m_n && ac >= 64) ? ac - 24 : ac];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ac = 0; m_shift = 0; m_cg = 0; m_id = 1; m_s = 0;
      m_d = 0; m_c = 0; m_b = 0; m_dl = 1; m_n = 0; m_f = 0; m_nib = 0;
      m_hi = 0; m_hold = 0; m_dout = 0; m_live = 1;
      for (int i = 0; i < 128; i++) mdd[i] = 8'h00;
      for (int i = 0; i < 64; i++) mcg[i] = 8'h00;
    end else begin
      bit mb; bit stat; logic [7:0] src; logic [7:0] b;
      mb = m_cnt != 0;
      if (m_cnt > 0) m_cnt--;
      if (bus_stb) begin
        stat = !bus_rs && bus_rw;
        if (!stat && mb) proto++;
        else begin
          src = bus_rs ? mread(m_ac) : {mb, 7'(m_ac)};
          if (!m_dl && !m_nib) begin
            m_hi = bus_din[7:4]; m_nib = 1;
            if (bus_rw) begin m_hold = src; m_dout = {src[7:4], 4'h0}; end
          end else begin
            b = m_dl ? bus_din : {m_hi, bus_din[7:4]};
            m_nib = 0;
            if (bus_rw) begin
              m_dout = m_dl ? src : {m_hold[3:0], 4'h0};
              if (bus_rs) begin m_ac = stepf(m_ac, m_id, m_cg, m_n); m_cnt = SHORT; end
            end else if (bus_rs) begin
              if (m_cg) mcg[m_ac % 64] = b; else mdd[(m_n && m_ac >= 64) ? m_ac - 24 : m_ac] = b;
              m_ac = stepf(m_ac, m_id, m_cg, m_n);
              if (m_s) m_shift = shf(m_shift, m_id, m_n);
              m_cnt = SHORT;
            end else begin
              if (b[7]) begin m_ac = b[6:0]; m_cg = 0; end
              else if (b[6]) begin m_ac = b[5:0]; m_cg = 1; end
              else if (b[5]) begin m_dl = b[4]; m_n = b[3]; m_f = b[2]; end
              else if (b[4]) begin
                if (b[3]) m_shift = shf(m_shift, !b[2], m_n);
                else m_ac = stepf(m_ac, b[2], m_cg, m_n);
              end
              else if (b[3]) begin m_d = b[2]; m_c = b[1]; m_b = b[0]; end
              else if (b[2]) begin m_id = b[1]; m_s = b[0]; end
              else if (b[1]) begin m_ac = 0; m_cg = 0; m_shift = 0; end
              else if (b[0]) begin
                m_ac = 0; m_cg = 0; m_shift = 0;
                for (int i = 0; i < 80; i++) mdd[i] = 8'h20;
              end
              if (b >= 8'h04) m_cnt = SHORT;
              else if (b != 8'h00) m_cnt = LONG;
            end
          end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && m_live) begin
    chk(busy == (m_cnt != 0), "R3 busy", busy, m_cnt != 0);
    chk(bus_dout == m_dout, "R1 bus_dout", bus_dout, m_dout);
    chk({disp_on, cursor_on, blink_on, two_line, tall_font} == {m_d, m_c, m_b, m_n, m_f},
        "R9 modes", {disp_on, cursor_on, blink_on, two_line, tall_font}, {m_d, m_c, m_b, m_n, m_f});
    chk(bus_8bit == m_dl, "R10 bus_8bit", bus_8bit, m_dl);
    chk(shift_pos == 7'(m_shift), "R8 shift_pos", shift_pos, m_shift);
  end

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic strobe(input bit rs, input bit rw, input logic [7:0] d);
    @(negedge clk);
    bus_stb = 1; bus_rs = rs; bus_rw = rw; bus_din = d;
    @(negedge clk);
    bus_stb = 0; bus_din = '0;
  endtask

  task automatic xfer_raw(input bit rs, input bit rw, input logic [7:0] d, output logic [7:0] q);
    if (m_dl) begin
      strobe(rs, rw, d); q = bus_dout;
    end else begin
      strobe(rs, rw, {d[7:4], 4'h0}); q[7:4] = bus_dout[7:4];
      strobe(rs, rw, {d[3:0], 4'h0}); q[3:0] = bus_dout[7:4];
    end
  endtask

  task automatic xfer(input bit rs, input bit rw, input logic [7:0] d, output logic [7:0] q);
    wait_idle();
    xfer_raw(rs, rw, d, q);
  endtask

  task automatic cmd(input logic [7:0] c);
    logic [7:0] q; xfer(0, 0, c, q);
  endtask
  task automatic wdat(input logic [7:0] c);
    logic [7:0] q; xfer(1, 0, c, q);
  endtask
  task automatic rdat(output logic [7:0] q);
    xfer(1, 1, 8'h00, q);
  endtask
  task automatic rstat(output logic [7:0] q);
    xfer(0, 1, 8'h00, q);
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    logic [7:0] q; int n; bit all_blank;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(!busy && !disp_on && !cursor_on && !blink_on && bus_8bit && !two_line && !tall_font
        && shift_pos == 0 && bus_dout == 0, "R13 reset outputs",
        {busy, disp_on, cursor_on, blink_on, bus_8bit, two_line, tall_font}, 7'b0000100);
    rstat(q); chk(q == 8'h00, "R13 reset status", q, 8'h00);

    // R6 increment, R3 short busy
    wdat(8'h41);
    busy_len(n); chk(n == SHORT, "R3 data write busy length", n, SHORT);
    wdat(8'h42); wdat(8'h43);
    rstat(q); chk(q == 8'h03, "R6 counter after three writes", q, 8'h03);
    cmd(8'h80);
    rdat(q); chk(q == 8'h41, "R6 readback 0", q, 8'h41);
    rdat(q); chk(q == 8'h42, "R6 readback 1", q, 8'h42);
    rdat(q); chk(q == 8'h43, "R6 readback 2", q, 8'h43);
    // R6 decrement
    cmd(8'h04); cmd(8'h82); wdat(8'h78);
    rstat(q); chk(q == 8'h01, "R6 decrement", q, 8'h01);
    // R1 status while busy shows bit 7
    cmd(8'h82); xfer_raw(0, 1, 8'h00, q);
    chk(q == 8'h82, "R1 status while busy", q, 8'h82);
    // R6 entry shift on writes only
    cmd(8'h07); cmd(8'h90); wdat(8'h55);
    wait_idle(); chk(shift_pos == 7'd1, "R6 shift on write", shift_pos, 1);
    rdat(q); wait_idle(); chk(shift_pos == 7'd1, "R6 no shift on read", shift_pos, 1);
    cmd(8'h06);
    // R5 home
    cmd(8'h02); busy_len(n); chk(n == LONG, "R5 R3 home busy length", n, LONG);
    chk(shift_pos == 0, "R5 home shift", shift_pos, 0);
    rstat(q); chk(q == 8'h00, "R5 home counter", q, 8'h00);
    rdat(q); chk(q == 8'h41, "R5 home keeps memory", q, 8'h41);
    // R8 cursor and display shift
    cmd(8'h85); cmd(8'h14); rstat(q); chk(q == 8'h06, "R8 cursor right", q, 8'h06);
    cmd(8'h10); cmd(8'h10); rstat(q); chk(q == 8'h04, "R8 cursor left", q, 8'h04);
    cmd(8'h18); wait_idle(); chk(shift_pos == 1, "R8 display shift left", shift_pos, 1);
    cmd(8'h1C); cmd(8'h1C); wait_idle(); chk(shift_pos == 79, "R8 shift wrap one-line", shift_pos, 79);
    // R9 display control
    cmd(8'h0F); wait_idle();
    chk({disp_on, cursor_on, blink_on} == 3'b111, "R9 display on", {disp_on, cursor_on, blink_on}, 3'b111);
    // R11 ignored while busy
    cmd(8'h08); xfer_raw(0, 0, 8'h0C, q); wait_idle();
    chk(disp_on == 0, "R11 command ignored", disp_on, 0);
    cmd(8'h80); xfer_raw(1, 0, 8'hEE, q);
    rdat(q); chk(q == 8'h41, "R11 data write ignored", q, 8'h41);
    chk(proto == 2, "R11 protocol errors flagged", proto, 2);
    // R7 one-line wrap
    cmd(8'hCF); wdat(8'h11); rstat(q); chk(q == 8'h00, "R7 one-line wrap", q, 8'h00);
    // R7 two-line wrap, R2 function set
    cmd(8'h38); wait_idle(); chk(two_line == 1, "R2 function set two-line", two_line, 1);
    cmd(8'hA7); wdat(8'h22); rstat(q); chk(q == 8'h40, "R7 27h to 40h", q, 8'h40);
    cmd(8'hE7); wdat(8'h33); rstat(q); chk(q == 8'h00, "R7 67h to 00h", q, 8'h00);
    cmd(8'h04); cmd(8'hC0); wdat(8'h5A); rstat(q); chk(q == 8'h27, "R7 40h down to 27h", q, 8'h27);
    cmd(8'h06);
    // R12 line two mapping
    cmd(8'h30); cmd(8'hA8); rdat(q); chk(q == 8'h5A, "R12 line-two location", q, 8'h5A);
    // R12 pattern memory and wrap
    cmd(8'h7F); wdat(8'h1F); rstat(q); chk(q == 8'h00, "R7 R12 pattern wrap", q, 8'h00);
    cmd(8'h7F); rdat(q); chk(q == 8'h1F, "R12 pattern readback", q, 8'h1F);
    cmd(8'hBF); rdat(q); chk(q != 8'h1F, "R12 display untouched", q, 8'h00);
    // R2 priority decode
    cmd(8'h3F); wait_idle(); chk(tall_font == 1, "R2 function set with low bits", tall_font, 1);
    cmd(8'h30);
    cmd(8'hFF); rstat(q); chk(q == 8'h7F, "R2 display address 7Fh", q, 8'h7F);
    cmd(8'h00); chk(!busy, "R2 zero byte no busy", busy, 0);
    // R10 four-bit transfers
    cmd(8'h20); wait_idle(); chk(bus_8bit == 0, "R10 enter four-bit", bus_8bit, 0);
    cmd(8'h8A); wdat(8'hC3); wdat(8'h96);
    rstat(q); chk(q == 8'h0C, "R10 status by halves", q, 8'h0C);
    cmd(8'h8A); rdat(q); chk(q == 8'hC3, "R10 read by halves", q, 8'hC3);
    rdat(q); chk(q == 8'h96, "R10 second byte", q, 8'h96);
    cmd(8'h30); wait_idle(); chk(bus_8bit == 1, "R10 back to eight-bit", bus_8bit, 1);
    // R4 clear
    cmd(8'h1C); cmd(8'h01); busy_len(n); chk(n == LONG, "R4 R3 clear busy length", n, LONG);
    chk(shift_pos == 0, "R4 clear shift", shift_pos, 0);
    rstat(q); chk(q == 8'h00, "R4 clear counter", q, 8'h00);
    all_blank = 1;
    for (int i = 0; i < 80; i++) begin
      rdat(q); if (q != 8'h20) all_blank = 0;
    end
    chk(all_blank, "R4 all blank", all_blank, 1);
    cmd(8'hFF); rdat(q); chk(q == 8'h00, "R4 beyond display untouched", q, 8'h00);

    wait_idle(); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule